// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms a data-memory address for a 16-bit processor with a segmented memory space. A request carries a mode word that selects which address terms are present: one of two base registers, one of two index registers, and a 16-bit displacement. It also carries the current values of those four registers, the four segment register values, and a prefix byte that may force a segment. The block adds the selected terms into a 16-bit effective address and picks the segment. If the request names no override, the segment follows the base register. It then forms the 20-bit physical address by placing the segment value four bits to the left and adding the offset. Register pairings that cannot be encoded are flagged as illegal, and no address is issued for them.

Requests use a valid/ready handshake. The result comes out of registers one clock after acceptance, with a single-cycle response strobe. A small two-state machine tracks this: `ST_IDLE` (no response on the outputs) and `ST_RESP` (a response is presented this cycle). An accepted request moves the machine from either state into `ST_RESP`. A cycle without acceptance returns it to `ST_IDLE`. Reset is synchronous and active-low.

Top module: `seg_ea_gen`

## Requirements
- R1: `req_ready` is 0 while reset is held and 1 from the first cycle after reset. A request is accepted on any rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the cycle after each accepting edge and 0 in every other cycle, so requests may be accepted back to back.
- R2: The mode bits are [0]=BX, [1]=BP, [2]=SI, [3]=DI, [4]=displacement. The effective address is the sum of the selected terms modulo 2^16, so any carry out of bit 15 is dropped (0x9100 + 0x7000 gives 0x0100).
- R3: A mode that selects both BX and BP, or both SI and DI, or no term at all, sets `rsp_illegal`. `rsp_ea`, `rsp_phys` and `rsp_seg` are then all 0. For legal modes `rsp_illegal` is 0.
- R4: With no override, the segment is SS when BP is selected, including BP combined with an index. In every other legal mode, including index-only and displacement-only, the segment is DS.
- R5: The override byte 0x26 selects ES, 0x2E selects CS, 0x36 selects SS and 0x3E selects DS. The override replaces the default. `rsp_seg` reports the segment used as 00=ES, 01=CS, 10=SS, 11=DS.
- R6: Any other override byte, including 0x00, has no effect, and the default segment of R4 is used.
- R7: An override affects only the request that carries it. The next request without an override uses its own default segment.
- R8: `rsp_phys` equals (segment value × 16 + effective address) modulo 2^20. For example, segment 0xFFF0 with offset 0x0200 gives 0x00100.
- R9: After reset, and before any request, `rsp_valid`, `rsp_illegal`, `rsp_ea`, `rsp_phys` and `rsp_seg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 5 | Term selects: [0] BX, [1] BP, [2] SI, [3] DI, [4] displacement |
| req_disp | input | 16 | Displacement term |
| req_ovr | input | 8 | Segment override prefix byte, or any other value for none |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ea | output | 16 | Effective address |
| rsp_seg | output | 2 | Segment used: 00 ES, 01 CS, 10 SS, 11 DS |
| rsp_phys | output | 20 | Physical address |
| rsp_illegal | output | 1 | Illegal term combination |

## Verification
The bench builds the block with its defaults, a 16-bit offset and a 4-bit segment shift, which gives a 20-bit physical address. With these widths, ordinary 16-bit operand values reach both wrap points. Register values whose sum passes 0xFFFF exercise the offset wrap. A segment of 0xFFF0 or higher pushes the physical sum past 20 bits. The four prefix bytes map onto all four segment codes, so every segment choice can be checked at full width.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ea_state_t;

    localparam int MODE_W   = 5;
    localparam int M_BX     = 0;
    localparam int M_BP     = 1;
    localparam int M_SI     = 2;
    localparam int M_DI     = 3;
    localparam int M_DISP   = 4;
    localparam int PREFIX_W = 8;

endpackage

// File: rtl/seg_ea_offset.sv
module seg_ea_offset
    import seg_ea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] bx,
    input  logic [ADDR_W-1:0] bp,
    input  logic [ADDR_W-1:0] si,
    input  logic [ADDR_W-1:0] di,
    output logic [ADDR_W-1:0] ea,
    output logic              illegal
);
    logic [ADDR_W-1:0] term [MODE_W];

    assign term[M_BX]   = bx;
    assign term[M_BP]   = bp;
    assign term[M_SI]   = si;
    assign term[M_DI]   = di;
    assign term[M_DISP] = disp;

    // Sum of the selected terms; carry past the top bit falls off.
    always_comb begin
        ea = '0;
        for (int k = 0; k < MODE_W; k++) begin
            if (mode[k]) ea = ea + term[k];
        end
    end

    assign illegal = (mode[M_BX] & mode[M_BP])
                   | (mode[M_SI] & mode[M_DI])
                   | (mode == '0);
endmodule

// File: rtl/seg_ea_segsel.sv
module seg_ea_segsel
    import seg_ea_pkg::*;
(
    input  logic                base_is_bp,
    input  logic [PREFIX_W-1:0] ovr,
    output seg_code_t           seg
);
    logic ovr_hit;

    // Prefix bytes 001ss110: bits [4:3] carry the segment number.
    assign ovr_hit = (ovr[7:5] == 3'b001) && (ovr[2:0] == 3'b110);

    always_comb begin
        if (ovr_hit)         seg = seg_code_t'(ovr[4:3]);
        else if (base_is_bp) seg = SEG_SS;
        else                 seg = SEG_DS;
    end
endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys
    import seg_ea_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4
) (
    input  seg_code_t                  seg,
    input  logic [ADDR_W-1:0]          es,
    input  logic [ADDR_W-1:0]          cs,
    input  logic [ADDR_W-1:0]          ss,
    input  logic [ADDR_W-1:0]          ds,
    input  logic [ADDR_W-1:0]          ea,
    output logic [ADDR_W+SEG_SHIFT-1:0] phys
);
    localparam int PHYS_W = ADDR_W + SEG_SHIFT;

    logic [ADDR_W-1:0] base_val;

    always_comb begin
        unique case (seg)
            SEG_ES: base_val = es;
            SEG_CS: base_val = cs;
            SEG_SS: base_val = ss;
            SEG_DS: base_val = ds;
        endcase
    end

    // Sum truncated to PHYS_W: the top carry wraps to address zero.
    assign phys = {base_val, {SEG_SHIFT{1'b0}}} + PHYS_W'(ea);
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import seg_ea_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [4:0]                  req_mode,
    input  logic [ADDR_W-1:0]           req_disp,
    input  logic [7:0]                  req_ovr,
    input  logic [ADDR_W-1:0]           reg_bx,
    input  logic [ADDR_W-1:0]           reg_bp,
    input  logic [ADDR_W-1:0]           reg_si,
    input  logic [ADDR_W-1:0]           reg_di,
    input  logic [ADDR_W-1:0]           seg_es,
    input  logic [ADDR_W-1:0]           seg_cs,
    input  logic [ADDR_W-1:0]           seg_ss,
    input  logic [ADDR_W-1:0]           seg_ds,
    output logic                        rsp_valid,
    output logic [ADDR_W-1:0]           rsp_ea,
    output logic [1:0]                  rsp_seg,
    output logic [ADDR_W+SEG_SHIFT-1:0] rsp_phys,
    output logic                        rsp_illegal
);
    localparam int PHYS_W = ADDR_W + SEG_SHIFT;

    ea_state_t         state_q, state_d;
    logic              ready_q;
    logic              accept;
    logic [ADDR_W-1:0] ea_c;
    logic              illegal_c;
    seg_code_t         seg_c;
    logic [PHYS_W-1:0] phys_c;

    seg_ea_offset #(.ADDR_W(ADDR_W)) u_offset (
        .mode    (req_mode),
        .disp    (req_disp),
        .bx      (reg_bx),
        .bp      (reg_bp),
        .si      (reg_si),
        .di      (reg_di),
        .ea      (ea_c),
        .illegal (illegal_c)
    );

    seg_ea_segsel u_segsel (
        .base_is_bp (req_mode[M_BP]),
        .ovr        (req_ovr),
        .seg        (seg_c)
    );

    seg_ea_phys #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
        .seg  (seg_c),
        .es   (seg_es),
        .cs   (seg_cs),
        .ss   (seg_ss),
        .ds   (seg_ds),
        .ea   (ea_c),
        .phys (phys_c)
    );

    assign accept    = req_valid & ready_q;
    assign req_ready = ready_q;
    assign rsp_valid = (state_q == ST_RESP);

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ea      <= '0;
            rsp_seg     <= '0;
            rsp_phys    <= '0;
            rsp_illegal <= 1'b0;
        end else if (accept) begin
            rsp_illegal <= illegal_c;
            rsp_ea      <= illegal_c ? '0 : ea_c;
            rsp_seg     <= illegal_c ? '0 : seg_c;
            rsp_phys    <= illegal_c ? '0 : phys_c;
        end
    end
endmodule

// File: rtl/seg_ea_gen_chk.sv
module seg_ea_gen_chk #(
    parameter int ADDR_W    = 16,
    parameter int SEG_SHIFT = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [4:0]                  req_mode,
    input logic [7:0]                  req_ovr,
    input logic [ADDR_W-1:0]           seg_es,
    input logic [ADDR_W-1:0]           seg_cs,
    input logic [ADDR_W-1:0]           seg_ss,
    input logic [ADDR_W-1:0]           seg_ds,
    input logic                        rsp_valid,
    input logic [ADDR_W-1:0]           rsp_ea,
    input logic [1:0]                  rsp_seg,
    input logic [ADDR_W+SEG_SHIFT-1:0] rsp_phys,
    input logic                        rsp_illegal
);
    localparam int PHYS_W = ADDR_W + SEG_SHIFT;

    logic              acc;
    logic [ADDR_W-1:0] es_q, cs_q, ss_q, ds_q;
    logic [ADDR_W-1:0] used_seg;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (acc) begin
            es_q <= seg_es;
            cs_q <= seg_cs;
            ss_q <= seg_ss;
            ds_q <= seg_ds;
        end
    end

    always_comb begin
        case (rsp_seg)
            2'b00:   used_seg = es_q;
            2'b01:   used_seg = cs_q;
            2'b10:   used_seg = ss_q;
            default: used_seg = ds_q;
        endcase
    end

    assert_resp_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    assert_illegal_zeroed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_ea == '0 && rsp_phys == '0 && rsp_seg == 2'b00));

    assert_bp_uses_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_mode == 5'b00010 && req_ovr == 8'h00) |=> (rsp_seg == 2'b10));

    assert_cs_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_ovr == 8'h2E) |=> (rsp_illegal || rsp_seg == 2'b01));

    assert_phys_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal) |->
            (rsp_phys == PHYS_W'({used_seg, {SEG_SHIFT{1'b0}}} + PHYS_W'(rsp_ea))));
endmodule

bind seg_ea_gen seg_ea_gen_chk #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .req_ovr     (req_ovr),
    .seg_es      (seg_es),
    .seg_cs      (seg_cs),
    .seg_ss      (seg_ss),
    .seg_ds      (seg_ds),
    .rsp_valid   (rsp_valid),
    .rsp_ea      (rsp_ea),
    .rsp_seg     (rsp_seg),
    .rsp_phys    (rsp_phys),
    .rsp_illegal (rsp_illegal)
);

// File: tb/seg_ea_gen_test.sv
module seg_ea_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int PW = 20;

    typedef struct {
        logic [AW-1:0] ea;
        logic [1:0]    seg;
        logic [PW-1:0] phys;
        logic          ill;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [4:0]    req_mode = '0;
    logic [AW-1:0] req_disp = '0;
    logic [7:0]    req_ovr = '0;
    logic [AW-1:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [AW-1:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_ea;
    logic [1:0]    rsp_seg;
    logic [PW-1:0] rsp_phys;
    logic          rsp_illegal;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   n_sent  = 0;
    int   n_seen  = 0;
    bit   done    = 1'b0;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_disp(req_disp), .req_ovr(req_ovr),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .rsp_valid(rsp_valid), .rsp_ea(rsp_ea), .rsp_seg(rsp_seg),
        .rsp_phys(rsp_phys), .rsp_illegal(rsp_illegal)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Expected result computed from the requirements.
    function automatic exp_t model(input logic [4:0] m, input logic [7:0] o, input string tag);
        exp_t e;
        logic [AW-1:0] s;
        logic [1:0]    sg;
        logic [AW-1:0] sv;
        e.tag = tag;
        e.ill = (m[0] && m[1]) || (m[2] && m[3]) || (m == 5'b0);
        s = '0;
        if (m[0]) s = s + reg_bx;
        if (m[1]) s = s + reg_bp;
        if (m[2]) s = s + reg_si;
        if (m[3]) s = s + reg_di;
        if (m[4]) s = s + req_disp;
        case (o)
            8'h26:   sg = 2'b00;
            8'h2E:   sg = 2'b01;
            8'h36:   sg = 2'b10;
            8'h3E:   sg = 2'b11;
            default: sg = m[1] ? 2'b10 : 2'b11;
        endcase
        case (sg)
            2'b00:   sv = seg_es;
            2'b01:   sv = seg_cs;
            2'b10:   sv = seg_ss;
            default: sv = seg_ds;
        endcase
        if (e.ill) begin
            e.ea = '0; e.seg = '0; e.phys = '0;
        end else begin
            e.ea = s; e.seg = sg;
            e.phys = ({4'h0, sv} << 4) + {4'h0, s};
        end
        return e;
    endfunction

    // Driver: presents one request for one cycle and queues its expectation.
    task automatic send(input logic [4:0] m, input logic [AW-1:0] d, input logic [7:0] o,
                        input string tag);
        @(negedge clk);
        req_mode  = m;
        req_disp  = d;
        req_ovr   = o;
        req_valid = 1'b1;
        sb.push_back(model(m, o, tag));
        n_sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compares every response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            n_seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R1", "response with no request outstanding");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_ea == e.ea && rsp_seg == e.seg && rsp_phys == e.phys
                      && rsp_illegal == e.ill, e.tag,
                      $sformatf("ea=%h seg=%0d phys=%h ill=%0b expected ea=%h seg=%0d phys=%h ill=%0b",
                                rsp_ea, rsp_seg, rsp_phys, rsp_illegal,
                                e.ea, e.seg, e.phys, e.ill));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        check(1'b0, "watchdog", "run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, "R1", $sformatf("ready in reset=%0b expected 0", req_ready));
        check(rsp_valid == 1'b0 && rsp_ea == '0 && rsp_phys == '0 && rsp_seg == '0
              && rsp_illegal == 1'b0, "R9",
              $sformatf("reset outputs v=%0b ea=%h phys=%h expected all 0", rsp_valid, rsp_ea, rsp_phys));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", $sformatf("ready after reset=%0b expected 1", req_ready));
        check(rsp_valid == 1'b0, "R9", $sformatf("valid before request=%0b expected 0", rsp_valid));

        seg_es = 16'h3000; seg_cs = 16'h1000; seg_ss = 16'h4000; seg_ds = 16'h2000;
        reg_bx = 16'h0100; reg_bp = 16'h0500; reg_si = 16'h0200; reg_di = 16'h0030;

        // Back-to-back group (R1) covering modes and defaults.
        send(5'b10000, 16'h1234, 8'h00, "R2 direct");
        send(5'b00001, 16'h0000, 8'h00, "R4 bx default DS");
        send(5'b00010, 16'h0000, 8'h00, "R4 bp default SS");
        send(5'b00100, 16'h0000, 8'h00, "R4 si default DS");
        send(5'b11000, 16'h0008, 8'h00, "R2 di+disp");
        send(5'b01010, 16'h0000, 8'h00, "R4 bp+di SS");
        send(5'b00101, 16'h0000, 8'h00, "R4 bx+si DS");
        send(5'b10101, 16'h0700, 8'h2E, "R5 worked CS");
        idle(2);

        // Illegal pairings.
        send(5'b00011, 16'h0000, 8'h00, "R3 two bases");
        send(5'b01100, 16'h0000, 8'h2E, "R3 two indexes");
        send(5'b00000, 16'h0000, 8'h00, "R3 empty mode");
        idle(1);

        // Overrides and their scope.
        send(5'b00010, 16'h0000, 8'h26, "R5 bp to ES");
        send(5'b00001, 16'h0000, 8'h36, "R5 bx to SS");
        send(5'b00010, 16'h0000, 8'h3E, "R5 bp to DS");
        send(5'b00010, 16'h0000, 8'h2F, "R6 bad code");
        send(5'b00010, 16'h0000, 8'h16, "R6 bad code");
        send(5'b00010, 16'h0000, 8'h00, "R7 override gone");
        idle(1);

        // Wraparounds.
        reg_bx = 16'h9100; seg_ds = 16'h1500;
        send(5'b10001, 16'h7000, 8'h00, "R2 offset wrap");
        idle(1);
        reg_bx = 16'h0100; seg_ds = 16'hFFF0;
        send(5'b10001, 16'h0100, 8'h00, "R8 phys wrap");
        idle(1);
        reg_bp = 16'hFFFF; reg_di = 16'hFFFF; seg_ss = 16'hFFFF;
        send(5'b11010, 16'hFFFF, 8'h00, "R8 both wraps");
        idle(4);

        check(n_seen == n_sent && sb.size() == 0, "R1",
              $sformatf("responses=%0d expected %0d", n_seen, n_sent));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule